// File: doc/BRIEF.md
# Masked Set/Clear Output Port

This block is an eight-pin general-purpose output port. The value behind the pins sits in an internal port register. That register never takes a plain write. It changes only through two masked commands: one raises the selected bits and the other lowers them. Each command arrives as a single-cycle strobe with a 4-bit opcode and an 8-bit mask. Bits whose mask position holds 0 keep their value.

The pins are active-low. A pin driven from the register shows the inverse of its bit, so a 1 in the register pulls the pin low. A 6-bit selection input chooses a source for each of pins 2 to 7: the register, or an internal status signal that passes straight through. Pin 1 can be handed to a mode-controlled alternate signal. Pin 0 has two possible overrides. The first is an alternate signal. The second is receiver flow control, which has priority and drives the pin with the NAND of register bit 0 and the receiver's RTS request. Turning flow control on or off never changes the stored bit, so the pin falls back to register control as soon as flow control is off.

Top module: `opport_setclr`

## Requirements
- R1: After reset every register bit is 0, so with register sourcing on every pin all eight pins are 1.
- R2: A strobe with opcode 0xE sets to 1 each register bit whose mask bit is 1 and leaves all other bits unchanged; the effect is visible from the clock edge that samples the strobe.
- R3: A strobe with opcode 0xF clears to 0 each register bit whose mask bit is 1 and leaves all other bits unchanged.
- R4: The register holds its value on a cycle with no strobe, or on a strobe whose opcode is anything other than 0xE or 0xF.
- R5: A pin sourced from the register is the inverse of its bit. Pins 2 to 7 use this source when alt_sel bit (pin-2) is 0, pin 1 when p1_alt_en is 0, and pin 0 when both rts_flow_en and p0_alt_en are 0.
- R6: When alt_sel bit (pin-2) is 1, pin k (2 to 7) equals alt_sig bit (k-2), whatever the register holds.
- R7: When rts_flow_en is 1, pin 0 equals NOT(register bit 0 AND rx_rts), whatever the value of p0_alt_en.
- R8: Changing rts_flow_en never alters register bit 0. After flow control is turned off, pin 0 again follows the register.
- R9: When rts_flow_en is 0 and p0_alt_en is 1, pin 0 equals p0_alt.
- R10: When p1_alt_en is 1, pin 1 equals p1_alt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Opcode: 0xE sets bits, 0xF clears bits |
| cmd_data | input | 8 | Bit mask for the command |
| alt_sel | input | 6 | Per-pin source select for pins 2..7 (1 = alt_sig) |
| alt_sig | input | 6 | Internal status signals for pins 2..7 |
| p1_alt_en | input | 1 | Hand pin 1 to p1_alt |
| p1_alt | input | 1 | Alternate signal for pin 1 |
| p0_alt_en | input | 1 | Hand pin 0 to p0_alt |
| p0_alt | input | 1 | Alternate signal for pin 0 |
| rts_flow_en | input | 1 | Receiver flow control owns pin 0 |
| rx_rts | input | 1 | Receiver RTS request (1 = ready to receive) |
| out_pins | output | 8 | Active-low output pins |

## Verification
The assertions assume that the opcode and mask are stable and known whenever the strobe is high. They also assume that the configuration and alternate inputs change only between clock edges, because the pins are combinational and the checks sample them at the edge. The bench drives every input on the falling edge, so nothing changes near a rising edge. Random opcodes include values other than 0xE and 0xF, so the check that such commands are ignored is exercised. The configuration inputs are randomized on their own, independently of the commands.

// File: rtl/opport_setclr.sv
module opport_setclr #(
  parameter int WIDTH = 8,
  parameter logic [3:0] OP_SET = 4'hE,
  parameter logic [3:0] OP_CLR = 4'hF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [3:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_data,
  input  logic [WIDTH-3:0] alt_sel,
  input  logic [WIDTH-3:0] alt_sig,
  input  logic             p1_alt_en,
  input  logic             p1_alt,
  input  logic             p0_alt_en,
  input  logic             p0_alt,
  input  logic             rts_flow_en,
  input  logic             rx_rts,
  output logic [WIDTH-1:0] out_pins
);

  logic [WIDTH-1:0] port_q;
  wire do_set = cmd_stb && (cmd_op == OP_SET);
  wire do_clr = cmd_stb && (cmd_op == OP_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      port_q <= '0;
    else if (do_set) port_q <= port_q | cmd_data;
    else if (do_clr) port_q <= port_q & ~cmd_data;
  end

  assign out_pins[0] = rts_flow_en ? ~(port_q[0] & rx_rts)
                     : p0_alt_en   ? p0_alt
                     :               ~port_q[0];
  assign out_pins[1] = p1_alt_en ? p1_alt : ~port_q[1];

  for (genvar k = 2; k < WIDTH; k++) begin : g_pin
    assign out_pins[k] = alt_sel[k-2] ? alt_sig[k-2] : ~port_q[k];
  end

endmodule

module opport_setclr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_stb,
  input logic [3:0]       cmd_op,
  input logic [WIDTH-1:0] cmd_data,
  input logic [WIDTH-3:0] alt_sel,
  input logic [WIDTH-3:0] alt_sig,
  input logic             rts_flow_en,
  input logic             rx_rts,
  input logic [WIDTH-1:0] port_q,
  input logic [WIDTH-1:0] out_pins
);

  // R2
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_op == 4'hE) |=> port_q == ($past(port_q) | $past(cmd_data)));

  // R3
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_op == 4'hF) |=> port_q == ($past(port_q) & ~$past(cmd_data)));

  // R4
  hold_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && (cmd_op == 4'hE || cmd_op == 4'hF)) |=> $stable(port_q));

  // R5
  inv_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_pins[WIDTH-1:2] ^ port_q[WIDTH-1:2]) | alt_sel) == '1);

  // R6
  alt_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_pins[WIDTH-1:2] ^ alt_sig) & alt_sel) == '0);

  // R7
  rts_nand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_flow_en |-> out_pins[0] == !(port_q[0] && rx_rts));

endmodule

bind opport_setclr opport_setclr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
  .cmd_data(cmd_data), .alt_sel(alt_sel), .alt_sig(alt_sig),
  .rts_flow_en(rts_flow_en), .rx_rts(rx_rts), .port_q(port_q),
  .out_pins(out_pins)
);

// File: tb/opport_setclr_bench.sv
`timescale 1ns/1ps
module opport_setclr_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_stb = 0;
  logic [3:0] cmd_op = 0;
  logic [7:0] cmd_data = 0;
  logic [5:0] alt_sel = 0, alt_sig = 0;
  logic p1_alt_en = 0, p1_alt = 0, p0_alt_en = 0, p0_alt = 0;
  logic rts_flow_en = 0, rx_rts = 0;
  logic [7:0] out_pins;
  logic [7:0] model = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  opport_setclr u_opport_setclr (.*);

  function automatic logic [7:0] exp_pins(logic [7:0] r);
    logic [7:0] p;
    p[0] = rts_flow_en ? ~(r[0] & rx_rts) : (p0_alt_en ? p0_alt : ~r[0]);
    p[1] = p1_alt_en ? p1_alt : ~r[1];
    for (int k = 2; k < 8; k++) p[k] = alt_sel[k-2] ? alt_sig[k-2] : ~r[k];
    return p;
  endfunction

  function automatic logic [7:0] next_reg(logic [7:0] r, logic [3:0] op, logic [7:0] d);
    if (op == 4'hE) return r | d;
    if (op == 4'hF) return r & ~d;
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (out_pins !== exp) begin
      errors++;
      $display("FAIL %s pins=%h expected=%h", tag, out_pins, exp);
    end
  endtask

  task automatic cmd(logic [3:0] op, logic [7:0] d);
    @(negedge clk);
    cmd_stb = 1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_stb = 0;
    model = next_reg(model, op, d);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    #35 rst_n = 1;
    @(negedge clk);
    check("R1 reset state", 8'hFF);
    cmd(4'hE, 8'hA5); check("R2 set mask A5", exp_pins(model));
    cmd(4'hE, 8'h0F); check("R2 set mask 0F", 8'h50);
    cmd(4'hF, 8'h81); check("R3 clear mask 81", 8'hD1);
    cmd(4'h3, 8'hFF); check("R4 other opcode ignored", 8'hD1);
    @(negedge clk); cmd_op = 4'hE; cmd_data = 8'hFF;
    @(negedge clk); check("R4 no strobe", 8'hD1);
    check("R5 inversion", ~model);
    alt_sel = 6'b101010; alt_sig = 6'b110011;
    #1 check("R6 alternate pins", exp_pins(model));
    alt_sel = 0;
    cmd(4'hF, 8'h01);
    rts_flow_en = 1; rx_rts = 1; p0_alt_en = 1; p0_alt = 0;
    #1 check("R7 nand with bit0=0", exp_pins(model));
    cmd(4'hE, 8'h01);
    check("R7 nand active", exp_pins(model));
    rx_rts = 0; #1 check("R7 rts idle", exp_pins(model));
    rts_flow_en = 0; p0_alt_en = 0;
    #1 check("R8 back to register", 8'hFE & exp_pins(model));
    rts_flow_en = 1; @(negedge clk); rts_flow_en = 0; @(negedge clk);
    check("R8 bit0 kept", exp_pins(model));
    p0_alt_en = 1; p0_alt = 1; #1 check("R9 pin0 alternate", exp_pins(model));
    p1_alt_en = 1; p1_alt = 0; #1 check("R10 pin1 alternate", exp_pins(model));
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      case ($urandom % 3) 0: op = 4'hE; 1: op = 4'hF; default: op = 4'($urandom); endcase
      alt_sel = 6'($urandom); alt_sig = 6'($urandom);
      p1_alt_en = 1'($urandom); p1_alt = 1'($urandom);
      p0_alt_en = 1'($urandom); p0_alt = 1'($urandom);
      rts_flow_en = 1'($urandom); rx_rts = 1'($urandom);
      cmd(op, 8'($urandom));
      check("R2 R3 R4 R5 R6 R7 R9 R10 random", exp_pins(model));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule